// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register storage of a 32-bit processor core whose visible register set depends on the current execution mode. Two combinational read ports and one write port are addressed by a 4-bit logical register number. A 5-bit mode input selects how each logical number is steered onto physical storage. Thirty physical general-purpose registers sit behind the logical numbers 0 to 14. Logical number 15 is the program counter. That value comes from outside the block and is returned word aligned.

The fast-interrupt mode has private copies of registers 8 to 14. Each of the other four exception modes (normal interrupt, supervisor, abort, undefined) has private copies of registers 13 and 14 only. System mode is privileged but sees exactly the user registers. A separate port reads and writes one saved status word per exception mode, which makes five such words. User and system mode have no saved status word. A write to logical 15 is not stored. Instead it is presented on a branch-request output in the same cycle so that the fetch logic can redirect.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every general-purpose register and every saved status word to zero.
- R2: Logical registers 0 to 7 are one physical set shared by all modes.
- R3: Registers 8 to 12 are private in fast-interrupt mode (10001). Every other mode reads and writes the user copy.
- R4: Registers 13 and 14 have separate copies for user, fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011). System mode (11111) uses the user copy, and user mode is 10000.
- R5: A mode input value that is none of the seven codes in R3 and R4 behaves as user mode (10000) for both register and saved-status access.
- R6: A read of logical 15 on either port returns `pc_i` with bits [1:0] forced to zero.
- R7: A write to logical 15 changes no register. In the same cycle it raises `br_req_o`, with `br_tgt_o` equal to the written data. `br_req_o` is low otherwise.
- R8: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the old value, and the next cycle returns the new value.
- R9: The saved-status port reaches a separate word in each of the five exception modes. In user, system or any unlisted mode, writes are ignored and reads return zero.
- R10: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current execution mode code |
| rda_idx_i | input | 4 | Logical register number, read port A |
| rda_data_o | output | 32 | Read data, port A |
| rdb_idx_i | input | 4 | Logical register number, read port B |
| rdb_data_o | output | 32 | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Logical register number to write |
| wr_data_i | input | 32 | Write data |
| pc_i | input | 32 | Program counter value supplied from outside |
| br_req_o | output | 1 | A write targeted logical 15 this cycle |
| br_tgt_o | output | 32 | Target carried with the branch request |
| sts_we_i | input | 1 | Saved-status write enable |
| sts_wdata_i | input | 32 | Saved-status write data |
| sts_rdata_o | output | 32 | Saved-status read data for the current mode |

## Verification
The write-visibility and hold properties only conclude something when the mode and read index stay the same from one cycle to the next. They assume the mode code identifies one bank for both cycles. When the mode or index changes, they draw no conclusion. The stimulus switches modes freely, including unlisted codes. It also holds mode and index steady across directed write-then-read pairs, so that those properties are exercised. Every input is driven well away from the clock edge, so the properties never see a value that changes at the sampling instant.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int XLEN      = 32;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int NUM_GPR   = 30;
    localparam int GPR_AW    = $clog2(NUM_GPR);
    localparam int NUM_STS   = 5;
    localparam int STS_AW    = $clog2(NUM_STS);
    localparam int PC_IDX    = 15;
    localparam int FIQ_FIRST = 8;   // first register privately banked in fast-interrupt mode
    localparam int SP_IDX    = 13;  // first register banked in every exception mode
    localparam int FIQ_BASE  = 15;  // physical slot of the fast-interrupt r8
    localparam int EXC_BASE  = 22;  // physical slot of the interrupt-mode r13

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic              en;
        logic [GPR_AW-1:0] addr;
        logic [XLEN-1:0]   data;
    } gpr_wr_t;

    // System mode and unlisted codes fold onto the user bank.
    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_FIQ;
            MODE_IRQ: return BANK_IRQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_UND: return BANK_UND;
            default:  return BANK_USR;
        endcase
    endfunction

    // Physical slot for a logical number 0..14 in a given bank.
    function automatic logic [GPR_AW-1:0] phys_of(input logic [IDX_W-1:0] idx,
                                                  input bank_e b);
        int i;
        int p;
        i = int'(idx);
        if (i < FIQ_FIRST || i == PC_IDX) begin
            p = (i == PC_IDX) ? 0 : i;
        end else if (i < SP_IDX) begin
            p = (b == BANK_FIQ) ? FIQ_BASE + (i - FIQ_FIRST) : i;
        end else if (b == BANK_USR) begin
            p = i;
        end else if (b == BANK_FIQ) begin
            p = FIQ_BASE + (i - FIQ_FIRST);
        end else begin
            p = EXC_BASE + 2 * (int'(b) - int'(BANK_IRQ)) + (i - SP_IDX);
        end
        return GPR_AW'(p);
    endfunction

endpackage

// File: rtl/brf_bank_decode.sv
module brf_bank_decode
    import bankreg_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic [MODE_W-1:0]           mode_i,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    output logic [NRD-1:0][GPR_AW-1:0]  rd_phys_o,
    output logic [NRD-1:0]              rd_is_pc_o,
    output logic [GPR_AW-1:0]           wr_phys_o,
    output logic                        wr_is_pc_o,
    output logic [STS_AW-1:0]           sts_slot_o,
    output logic                        sts_ok_o
);
    bank_e bank;

    always_comb bank = bank_of(mode_i);

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_phys_o[p]  = phys_of(rd_idx_i[p], bank);
            rd_is_pc_o[p] = (rd_idx_i[p] == IDX_W'(PC_IDX));
        end
    end

    always_comb begin
        wr_phys_o  = phys_of(wr_idx_i, bank);
        wr_is_pc_o = (wr_idx_i == IDX_W'(PC_IDX));
        sts_ok_o   = (bank != BANK_USR);
        sts_slot_o = sts_ok_o ? STS_AW'(int'(bank) - 1) : '0;
    end

endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int DEPTH  = NUM_GPR,
    parameter int NRD    = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  gpr_wr_t                      wr_i,
    input  logic [NRD-1:0][AW-1:0]       rd_addr_i,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (wr_i.en && wr_i.addr == AW'(e)) begin
                mem[e] <= wr_i.data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data_o[p] = (rd_addr_i[p] <= LAST) ? mem[rd_addr_i[p]] : '0;
        end
    end

endmodule

// File: rtl/brf_sts_store.sv
module brf_sts_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int NSLOT  = NUM_STS,
    localparam int SW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW-1:0]     slot_i,
    input  logic              ok_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] sts [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[s] <= '0;
            end else if (we_i && ok_i && slot_i == SW'(s)) begin
                sts[s] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (ok_i && slot_i == SW'(s)) rdata_o = sts[s];
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rda_idx_i,
    output logic [31:0]       rda_data_o,
    input  logic [3:0]        rdb_idx_i,
    output logic [31:0]       rdb_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [31:0]       wr_data_i,
    input  logic [31:0]       pc_i,
    output logic              br_req_o,
    output logic [31:0]       br_tgt_o,
    input  logic              sts_we_i,
    input  logic [31:0]       sts_wdata_i,
    output logic [31:0]       sts_rdata_o
);
    localparam int NRD = 2;

    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0][GPR_AW-1:0] rd_phys;
    logic [NRD-1:0]             rd_is_pc;
    logic [NRD-1:0][XLEN-1:0]   rd_store;
    logic [NRD-1:0][XLEN-1:0]   rd_out;
    logic [GPR_AW-1:0]          wr_phys;
    logic                       wr_is_pc;
    logic [STS_AW-1:0]          sts_slot;
    logic                       sts_ok;
    gpr_wr_t                    gpr_wr;
    logic [XLEN-1:0]            pc_aligned;

    assign rd_idx = {rdb_idx_i, rda_idx_i};

    brf_bank_decode #(.NRD(NRD)) dec_i (
        .mode_i     (mode_i),
        .rd_idx_i   (rd_idx),
        .wr_idx_i   (wr_idx_i),
        .rd_phys_o  (rd_phys),
        .rd_is_pc_o (rd_is_pc),
        .wr_phys_o  (wr_phys),
        .wr_is_pc_o (wr_is_pc),
        .sts_slot_o (sts_slot),
        .sts_ok_o   (sts_ok)
    );

    always_comb begin
        gpr_wr.en   = wr_en_i && !wr_is_pc;
        gpr_wr.addr = wr_phys;
        gpr_wr.data = wr_data_i;
    end

    brf_gpr_store #(.DATA_W(XLEN), .DEPTH(NUM_GPR), .NRD(NRD)) gpr_i (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (gpr_wr),
        .rd_addr_i (rd_phys),
        .rd_data_o (rd_store)
    );

    brf_sts_store #(.DATA_W(XLEN), .NSLOT(NUM_STS)) sts_i (
        .clk     (clk),
        .rst     (rst),
        .slot_i  (sts_slot),
        .ok_i    (sts_ok),
        .we_i    (sts_we_i),
        .wdata_i (sts_wdata_i),
        .rdata_o (sts_rdata_o)
    );

    assign pc_aligned = {pc_i[XLEN-1:2], 2'b00};

    for (genvar p = 0; p < NRD; p++) begin : g_out
        assign rd_out[p] = rd_is_pc[p] ? pc_aligned : rd_store[p];
    end

    assign rda_data_o = rd_out[0];
    assign rdb_data_o = rd_out[1];
    assign br_req_o   = wr_en_i && wr_is_pc;
    assign br_tgt_o   = wr_data_i;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  mode_i,
    input logic [3:0]  rda_idx_i,
    input logic [31:0] rda_data_o,
    input logic        wr_en_i,
    input logic [3:0]  wr_idx_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] pc_i,
    input logic        br_req_o,
    input logic [31:0] br_tgt_o,
    input logic        sts_we_i,
    input logic [31:0] sts_wdata_i,
    input logic [31:0] sts_rdata_o
);
    logic exc_mode;
    assign exc_mode = (mode_i == 5'b10001) || (mode_i == 5'b10010) || (mode_i == 5'b10011)
                   || (mode_i == 5'b10111) || (mode_i == 5'b11011);

    p_reset_clears_r1: assert property (@(posedge clk)
        ($past(rst) && rda_idx_i != 4'd15) |-> rda_data_o == 32'd0);

    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        rda_idx_i == 4'd15 |-> (rda_data_o[1:0] == 2'b00 && rda_data_o[31:2] == pc_i[31:2]));

    p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
        br_req_o |-> (wr_en_i && wr_idx_i == 4'd15 && br_tgt_o == wr_data_i));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i != 4'd15 && rda_idx_i == wr_idx_i)
        |=> (!$stable(mode_i) || !$stable(rda_idx_i) || rda_data_o == $past(wr_data_i)));

    p_read_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && rda_idx_i != 4'd15)
        |=> (!$stable(mode_i) || !$stable(rda_idx_i) || $stable(rda_data_o)));

    p_sts_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !exc_mode |-> sts_rdata_o == 32'd0);

    p_sts_write_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_we_i && exc_mode)
        |=> (!$stable(mode_i) || sts_rdata_o == $past(sts_wdata_i)));

endmodule

bind banked_regfile banked_regfile_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .rda_idx_i   (rda_idx_i),
    .rda_data_o  (rda_data_o),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .pc_i        (pc_i),
    .br_req_o    (br_req_o),
    .br_tgt_o    (br_tgt_o),
    .sts_we_i    (sts_we_i),
    .sts_wdata_i (sts_wdata_i),
    .sts_rdata_o (sts_rdata_o)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode_i = 5'b10000;
    logic [3:0]  rda_idx_i = '0;
    logic [3:0]  rdb_idx_i = '0;
    logic [31:0] rda_data_o, rdb_data_o;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] pc_i = '0;
    logic        br_req_o;
    logic [31:0] br_tgt_o;
    logic        sts_we_i = 1'b0;
    logic [31:0] sts_wdata_i = '0;
    logic [31:0] sts_rdata_o;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    banked_regfile dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .rda_idx_i(rda_idx_i), .rda_data_o(rda_data_o),
        .rdb_idx_i(rdb_idx_i), .rdb_data_o(rdb_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .pc_i(pc_i), .br_req_o(br_req_o), .br_tgt_o(br_tgt_o),
        .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i), .sts_rdata_o(sts_rdata_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_usr [0:14];
    logic [31:0] m_fiq [8:14];
    logic [31:0] m_exc [0:3][0:1];
    logic [31:0] m_sts [0:4];

    logic [4:0] all_modes [0:8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                                    5'b11011, 5'b11111, 5'b00000, 5'b10100};

    function automatic logic [4:0] canon(input logic [4:0] m);
        case (m)
            5'b10000, 5'b10001, 5'b10010, 5'b10011,
            5'b10111, 5'b11011, 5'b11111: return m;
            default: return 5'b10000;
        endcase
    endfunction

    function automatic int exc_slot(input logic [4:0] cm);
        case (cm)
            5'b10010: return 0;
            5'b10011: return 1;
            5'b10111: return 2;
            5'b11011: return 3;
            default:  return -1;
        endcase
    endfunction

    function automatic int sts_slot(input logic [4:0] cm);
        case (cm)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] m, input logic [3:0] idx,
                                               input logic [31:0] pc);
        logic [4:0] cm;
        int i;
        cm = canon(m);
        i = int'(idx);
        if (i == 15) return {pc[31:2], 2'b00};
        if (cm == 5'b10001 && i >= 8) return m_fiq[i];
        if (i >= 13 && exc_slot(cm) >= 0) return m_exc[exc_slot(cm)][i-13];
        return m_usr[i];
    endfunction

    task automatic model_write(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
        logic [4:0] cm;
        int i;
        cm = canon(m);
        i = int'(idx);
        if (i == 15) return;
        if (cm == 5'b10001 && i >= 8) m_fiq[i] = d;
        else if (i >= 13 && exc_slot(cm) >= 0) m_exc[exc_slot(cm)][i-13] = d;
        else m_usr[i] = d;
    endtask

    function automatic string tag_for(input logic [4:0] m, input logic [3:0] idx);
        if (idx == 4'd15) return "R6";
        if (canon(m) != m) return "R5";
        if (idx < 4'd8) return "R2";
        if (idx < 4'd13) return "R3";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
    task automatic step(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb,
                        input bit we, input logic [3:0] wi, input logic [31:0] wd,
                        input bit se, input logic [31:0] sd, input string tag);
        logic [31:0] pc, ea, eb, es;
        bit eq;
        int ss;
        pc = $urandom;
        mode_i = m; rda_idx_i = ra; rdb_idx_i = rb;
        wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
        sts_we_i = se; sts_wdata_i = sd; pc_i = pc;
        #2;
        ea = model_read(m, ra, pc);
        eb = model_read(m, rb, pc);
        ss = sts_slot(canon(m));
        es = (ss >= 0) ? m_sts[ss] : 32'd0;
        eq = we && (wi == 4'd15);
        check(rda_data_o === ea, (tag != "") ? tag : tag_for(m, ra), "port A", rda_data_o, ea);
        check(rdb_data_o === eb, (tag != "") ? tag : tag_for(m, rb), "port B", rdb_data_o, eb);
        check(sts_rdata_o === es, (tag != "") ? tag : "R9", "saved status", sts_rdata_o, es);
        check(br_req_o === eq, "R7", "branch request", {31'd0, br_req_o}, {31'd0, eq});
        if (eq) check(br_tgt_o === wd, "R7", "branch target", br_tgt_o, wd);
        @(posedge clk);
        if (!rst) begin
            if (we) model_write(m, wi, wd);
            if (se && ss >= 0) m_sts[ss] = sd;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 15; i++) m_usr[i] = '0;
        for (int i = 8; i < 15; i++) m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) begin m_exc[i][0] = '0; m_exc[i][1] = '0; end
        for (int i = 0; i < 5; i++) m_sts[i] = '0;

        // R1: reset state, with a write attempted while reset is held
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mode_i = 5'b10001; wr_en_i = 1'b1; wr_idx_i = 4'd9; wr_data_i = 32'hDEAD_BEEF;
        sts_we_i = 1'b1; sts_wdata_i = 32'hCAFE_0001;
        @(negedge clk);
        wr_en_i = 1'b0; sts_we_i = 1'b0;
        rst = 1'b0;
        for (int mi = 0; mi < 7; mi++)
            for (int r = 0; r < 15; r += 2)
                step(all_modes[mi], 4'(r), 4'(r + 1 > 14 ? 14 : r + 1), 0, 0, 0, 0, 0, "R1");

        // R2, R3, R4: fill every logical register in every mode, then read back everywhere
        for (int mi = 0; mi < 7; mi++)
            for (int r = 0; r < 15; r++)
                step(all_modes[mi], 4'(r), 4'(14 - r), 1, 4'(r),
                     {8'hA0 + 8'(mi), 16'h0000, 8'(r)}, 0, 0, "");
        for (int mi = 0; mi < 9; mi++)
            for (int r = 0; r < 15; r++)
                step(all_modes[mi], 4'(r), 4'(r), 0, 0, 0, 0, 0, "");

        // R8: read of the register being written returns the old value, then the new one
        step(5'b10011, 4'd13, 4'd13, 1, 4'd13, 32'h1357_9BDF, 0, 0, "R8");
        step(5'b10011, 4'd13, 4'd13, 0, 0, 0, 0, 0, "R8");
        step(5'b10001, 4'd10, 4'd2, 1, 4'd10, 32'h2468_ACE0, 0, 0, "R8");
        step(5'b10001, 4'd10, 4'd2, 0, 0, 0, 0, 0, "R8");

        // R10: two ports read different banked registers at once
        step(5'b10010, 4'd14, 4'd5, 0, 0, 0, 0, 0, "R10");
        step(5'b10001, 4'd12, 4'd15, 0, 0, 0, 0, 0, "R10");

        // R6, R7: program counter read and write
        for (int k = 0; k < 4; k++)
            step(all_modes[k], 4'd15, 4'd15, 1, 4'd15, 32'h8000_0000 + 32'(k), 0, 0, "");
        for (int mi = 0; mi < 7; mi++)
            step(all_modes[mi], 4'd0, 4'd14, 0, 0, 0, 0, 0, "R7");

        // R9: saved status per exception mode; ignored elsewhere
        for (int mi = 0; mi < 9; mi++)
            step(all_modes[mi], 4'd1, 4'd2, 0, 0, 0, 1, 32'h5A00_0000 + 32'(mi), "");
        for (int mi = 0; mi < 9; mi++)
            step(all_modes[mi], 4'd1, 4'd2, 0, 0, 0, 0, 0, "R9");

        // R5: unlisted mode codes write the user bank and no status word
        step(5'b00000, 4'd13, 4'd9, 1, 4'd13, 32'h0BAD_F00D, 1, 32'h1111_1111, "R5");
        step(5'b10000, 4'd13, 4'd9, 0, 0, 0, 0, 0, "R5");
        step(5'b10100, 4'd9, 4'd14, 1, 4'd9, 32'h0DEF_ACED, 0, 0, "R5");
        step(5'b11111, 4'd9, 4'd13, 0, 0, 0, 0, 0, "R5");

        // mixed traffic over all modes
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] m;
            m = all_modes[$urandom_range(0, 8)];
            step(m, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                 bit'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom,
                 bit'($urandom_range(0, 3) == 0), $urandom, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule